// File: doc/BRIEF.md
# Interlaced Monochrome Sync Generator

This block produces the full set of raster timing signals for a black-and-white interlaced camera from one master clock. Two static selects pick the TV standard (525-line or 625-line) and the sensor width (510-pixel or 760-pixel). These selects set the line length, the frame length and every pulse width. The block drives a horizontal drive pulse, a vertical drive pulse, composite sync, composite blanking and an odd/even field flag. Composite sync holds the normal line sync, the half-line equalizing pulses and the serrated vertical sync pulses.

All timing comes from one half-line position counter and one half-line index that runs over the whole frame. A frame holds an odd number of lines. Because of this, the even field starts in the middle of a line and the half-line offset between the fields needs no extra logic. Every output is registered, so each output lags the counter state by one clock. Outputs are active low, except the field flag. The selects are read continuously and must be changed only while reset is held.

Top module: `sync_gen_top`

## Requirements
- R1: `hd_n` falls once per line. The line length in clocks is LINE_510 (606) when `wide_760`=0, for both standards. When `wide_760`=1 it is LINE_760_EIA (910) when `std_ccir`=0 and LINE_760_CCIR (908) when `std_ccir`=1. A half-line is half of the line length.
- R2: At each line start `hd_n` goes low and stays low for HSYNC_510 (45) clocks when `wide_760`=0, or for HSYNC_760 (68) clocks when `wide_760`=1.
- R3: A frame has EIA_LINES (525) lines when `std_ccir`=0 and CCIR_LINES (625) lines when `std_ccir`=1. The frame is split into two fields of equal length, so `vd_n` falls every (lines × half-line) clocks.
- R4: `vd_n` stays low for 6 half-lines from the start of each field. `field_odd` is 1 during the odd field and 0 during the even field, and it changes on the same clock on which `vd_n` falls.
- R5: Equalizing pulses fill the 3 half-lines before vertical sync and the 3 half-lines after it. In each of these half-lines, `csync_n` is low for EQ_510 (22) or EQ_760 (34) clocks from the half-line start. This gives 12 such pulses per frame.
- R6: Vertical sync fills the 6 half-lines that follow the first equalizing group. In each of these half-lines, `csync_n` is low for (half-line − hsync width) clocks and then high for one hsync width. This gives 12 such pulses per frame.
- R7: `cblank_n` is low for the first HBLK clocks of every line. HBLK is 104 for 525-line 510H, 114 for 625-line 510H, 154 for 525-line 760H and 169 for 625-line 760H. `cblank_n` is also low without a break for the first 2×VBLK half-lines of each field, where VBLK is 20 lines for 525-line and 25 lines for 625-line. The odd-field blanking therefore lasts 2×VBLK half-lines plus HBLK clocks, and the even-field blanking lasts exactly 2×VBLK half-lines.
- R8: The odd field starts at a line start, so `vd_n` falls in the same cycle as `hd_n`. The even field starts at mid-line, so `hd_n` is high when `vd_n` falls.
- R9: While `rst_n` is low, `hd_n`, `vd_n`, `csync_n` and `cblank_n` are high and `field_odd` is 0, without waiting for a clock. On the first clock after release the odd field begins, so all four pulse outputs are low and `field_odd` is 1.
- R10: Outside the 12 half-lines of the vertical interval, `csync_n` carries only normal line sync. This is a low pulse one hsync width long at each line start, which gives (lines − 12) such pulses per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| std_ccir | input | 1 | 0: 525-line standard, 1: 625-line standard |
| wide_760 | input | 1 | 0: 510-pixel sensor, 1: 760-pixel sensor |
| hd_n | output | 1 | Horizontal drive, active low |
| vd_n | output | 1 | Vertical drive, active low |
| csync_n | output | 1 | Composite sync, active low |
| cblank_n | output | 1 | Composite blanking, active low |
| field_odd | output | 1 | 1 during the odd field |

## Verification
The bench builds the block with scaled parameters. Lines are 60, 92 or 88 clocks, frames are 25 or 31 lines, sync widths are 5 or 7 clocks, equalizing widths are 2 or 3 clocks, and vertical blanking is 10 or 12 lines. These values keep the pulse widths distinct from one another, so the bench can sort each composite sync pulse by its width. With them, two complete interlaced frames of each of the four standard/width combinations fit in a short run. Each run covers both field starts, the long blanking on each side of the half-line offset, and the per-frame counts of equalizing, serrated and normal sync pulses. The default parameters use the same paths, but their frames are too long for the run.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

  // Vertical interval layout, in half-lines from each field start
  localparam int PRE_EQ_HALVES  = 3;
  localparam int VSYNC_HALVES   = 6;
  localparam int POST_EQ_HALVES = 3;
  localparam int VD_HALVES      = 6;
  localparam int VINT_HALVES    = PRE_EQ_HALVES + VSYNC_HALVES + POST_EQ_HALVES;

  typedef enum logic [1:0] {
    RGN_ACTIVE  = 2'd0,
    RGN_PRE_EQ  = 2'd1,
    RGN_VSYNC   = 2'd2,
    RGN_POST_EQ = 2'd3
  } vregion_e;

  // Pick one of four values from the standard and width selects
  function automatic int pick_mode(input logic ccir, input logic wide,
                                   input int e510, input int c510,
                                   input int e760, input int c760);
    if (wide) return ccir ? c760 : e760;
    return ccir ? c510 : e510;
  endfunction

endpackage

// File: rtl/sync_mode_sel.sv
module sync_mode_sel
  import sync_gen_pkg::*;
#(
  parameter int EIA_LINES     = 525,
  parameter int CCIR_LINES    = 625,
  parameter int LINE_510      = 606,
  parameter int LINE_760_EIA  = 910,
  parameter int LINE_760_CCIR = 908,
  parameter int HSYNC_510     = 45,
  parameter int HSYNC_760     = 68,
  parameter int EQ_510        = 22,
  parameter int EQ_760        = 34,
  parameter int HBLK_EIA_510  = 104,
  parameter int HBLK_CCIR_510 = 114,
  parameter int HBLK_EIA_760  = 154,
  parameter int HBLK_CCIR_760 = 169,
  parameter int VBLK_EIA      = 20,
  parameter int VBLK_CCIR     = 25,
  parameter int POS_W         = 9,
  parameter int IDX_W         = 11
) (
  input  logic             ccir_i,
  input  logic             wide_i,
  output logic [POS_W-1:0] half_len_o,
  output logic [POS_W-1:0] hsync_w_o,
  output logic [POS_W-1:0] eq_w_o,
  output logic [POS_W-1:0] hblank_w_o,
  output logic [IDX_W-1:0] frame_lines_o,
  output logic [IDX_W-1:0] vblank_halves_o
);

  localparam int HALF_510      = LINE_510 / 2;
  localparam int HALF_760_EIA  = LINE_760_EIA / 2;
  localparam int HALF_760_CCIR = LINE_760_CCIR / 2;

  always_comb begin
    half_len_o      = POS_W'(pick_mode(ccir_i, wide_i, HALF_510, HALF_510,
                                       HALF_760_EIA, HALF_760_CCIR));
    hsync_w_o       = POS_W'(pick_mode(ccir_i, wide_i, HSYNC_510, HSYNC_510,
                                       HSYNC_760, HSYNC_760));
    eq_w_o          = POS_W'(pick_mode(ccir_i, wide_i, EQ_510, EQ_510,
                                       EQ_760, EQ_760));
    hblank_w_o      = POS_W'(pick_mode(ccir_i, wide_i, HBLK_EIA_510, HBLK_CCIR_510,
                                       HBLK_EIA_760, HBLK_CCIR_760));
    frame_lines_o   = IDX_W'(pick_mode(ccir_i, wide_i, EIA_LINES, CCIR_LINES,
                                       EIA_LINES, CCIR_LINES));
    vblank_halves_o = IDX_W'(2 * pick_mode(ccir_i, wide_i, VBLK_EIA, VBLK_CCIR,
                                           VBLK_EIA, VBLK_CCIR));
  end

endmodule

// File: rtl/sync_counters.sv
module sync_counters #(
  parameter int POS_W = 9,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] half_len_i,
  input  logic [IDX_W-1:0] frame_lines_i,
  output logic [POS_W-1:0] pos_o,
  output logic             line_start_o,
  output logic             field_even_o,
  output logic [IDX_W-1:0] fidx_o
);

  logic [POS_W-1:0] pos_q;
  logic [IDX_W-1:0] hidx_q;
  logic [IDX_W-1:0] frame_halves;
  logic             half_end;
  logic             frame_end;

  assign frame_halves = frame_lines_i << 1;
  assign half_end     = (pos_q >= half_len_i - POS_W'(1));
  assign frame_end    = (hidx_q >= frame_halves - IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      hidx_q <= '0;
    end else if (half_end) begin
      pos_q  <= '0;
      hidx_q <= frame_end ? '0 : hidx_q + IDX_W'(1);
    end else begin
      pos_q  <= pos_q + POS_W'(1);
    end
  end

  // An odd line count puts the second field start in mid-line
  assign field_even_o = (hidx_q >= frame_lines_i);
  assign fidx_o       = field_even_o ? (hidx_q - frame_lines_i) : hidx_q;
  assign line_start_o = ~hidx_q[0];
  assign pos_o        = pos_q;

  assert_pos_bound_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < half_len_i);

  assert_idx_bound_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    hidx_q < frame_halves);

endmodule

// File: rtl/sync_wave.sv
module sync_wave
  import sync_gen_pkg::*;
#(
  parameter int POS_W = 9,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_i,
  input  logic             line_start_i,
  input  logic             field_even_i,
  input  logic [IDX_W-1:0] fidx_i,
  input  logic [POS_W-1:0] half_len_i,
  input  logic [POS_W-1:0] hsync_w_i,
  input  logic [POS_W-1:0] eq_w_i,
  input  logic [POS_W-1:0] hblank_w_i,
  input  logic [IDX_W-1:0] vblank_halves_i,
  output logic             hd_n_o,
  output logic             vd_n_o,
  output logic             csync_n_o,
  output logic             cblank_n_o,
  output logic             field_odd_o
);

  vregion_e region;
  logic     hd_low, vd_low, cs_low, blk_low;
  logic     hd_n_q, vd_n_q, cs_n_q, blk_n_q, field_odd_q;

  always_comb begin
    if (fidx_i < IDX_W'(PRE_EQ_HALVES))
      region = RGN_PRE_EQ;
    else if (fidx_i < IDX_W'(PRE_EQ_HALVES + VSYNC_HALVES))
      region = RGN_VSYNC;
    else if (fidx_i < IDX_W'(VINT_HALVES))
      region = RGN_POST_EQ;
    else
      region = RGN_ACTIVE;
  end

  always_comb begin
    hd_low  = line_start_i && (pos_i < hsync_w_i);
    vd_low  = (fidx_i < IDX_W'(VD_HALVES));
    blk_low = (fidx_i < vblank_halves_i) || (line_start_i && (pos_i < hblank_w_i));
    unique case (region)
      RGN_PRE_EQ,
      RGN_POST_EQ: cs_low = (pos_i < eq_w_i);
      RGN_VSYNC:   cs_low = (pos_i < (half_len_i - hsync_w_i));
      default:     cs_low = hd_low;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_n_q      <= 1'b1;
      vd_n_q      <= 1'b1;
      cs_n_q      <= 1'b1;
      blk_n_q     <= 1'b1;
      field_odd_q <= 1'b0;
    end else begin
      hd_n_q      <= ~hd_low;
      vd_n_q      <= ~vd_low;
      cs_n_q      <= ~cs_low;
      blk_n_q     <= ~blk_low;
      field_odd_q <= ~field_even_i;
    end
  end

  assign hd_n_o      = hd_n_q;
  assign vd_n_o      = vd_n_q;
  assign csync_n_o   = cs_n_q;
  assign cblank_n_o  = blk_n_q;
  assign field_odd_o = field_odd_q;

  assert_field_toggle_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vd_n_q) |-> (field_odd_q != $past(field_odd_q)));

  assert_odd_align_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vd_n_q) && field_odd_q) |-> !hd_n_q);

  assert_even_offset_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vd_n_q) && !field_odd_q) |-> hd_n_q);

  assert_vd_blanked_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !vd_n_q |-> !blk_n_q);

  assert_hd_blanked_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !hd_n_q |-> !blk_n_q);

endmodule

// File: rtl/sync_gen_top.sv
module sync_gen_top #(
  parameter int EIA_LINES     = 525,
  parameter int CCIR_LINES    = 625,
  parameter int LINE_510      = 606,
  parameter int LINE_760_EIA  = 910,
  parameter int LINE_760_CCIR = 908,
  parameter int HSYNC_510     = 45,
  parameter int HSYNC_760     = 68,
  parameter int EQ_510        = 22,
  parameter int EQ_760        = 34,
  parameter int HBLK_EIA_510  = 104,
  parameter int HBLK_CCIR_510 = 114,
  parameter int HBLK_EIA_760  = 154,
  parameter int HBLK_CCIR_760 = 169,
  parameter int VBLK_EIA      = 20,
  parameter int VBLK_CCIR     = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic std_ccir,
  input  logic wide_760,
  output logic hd_n,
  output logic vd_n,
  output logic csync_n,
  output logic cblank_n,
  output logic field_odd
);

  localparam int MAX_LINE_760 = (LINE_760_EIA > LINE_760_CCIR) ? LINE_760_EIA : LINE_760_CCIR;
  localparam int MAX_LINE     = (MAX_LINE_760 > LINE_510) ? MAX_LINE_760 : LINE_510;
  localparam int POS_W        = $clog2(MAX_LINE / 2 + 1);
  localparam int MAX_LINES    = (EIA_LINES > CCIR_LINES) ? EIA_LINES : CCIR_LINES;
  localparam int IDX_W        = $clog2(2 * MAX_LINES + 1);

  logic [POS_W-1:0] half_len, hsync_w, eq_w, hblank_w, pos;
  logic [IDX_W-1:0] frame_lines, vblank_halves, fidx;
  logic             line_start, field_even;

  sync_mode_sel #(
    .EIA_LINES(EIA_LINES), .CCIR_LINES(CCIR_LINES),
    .LINE_510(LINE_510), .LINE_760_EIA(LINE_760_EIA), .LINE_760_CCIR(LINE_760_CCIR),
    .HSYNC_510(HSYNC_510), .HSYNC_760(HSYNC_760),
    .EQ_510(EQ_510), .EQ_760(EQ_760),
    .HBLK_EIA_510(HBLK_EIA_510), .HBLK_CCIR_510(HBLK_CCIR_510),
    .HBLK_EIA_760(HBLK_EIA_760), .HBLK_CCIR_760(HBLK_CCIR_760),
    .VBLK_EIA(VBLK_EIA), .VBLK_CCIR(VBLK_CCIR),
    .POS_W(POS_W), .IDX_W(IDX_W)
  ) sel_i (
    .ccir_i(std_ccir), .wide_i(wide_760),
    .half_len_o(half_len), .hsync_w_o(hsync_w), .eq_w_o(eq_w),
    .hblank_w_o(hblank_w), .frame_lines_o(frame_lines),
    .vblank_halves_o(vblank_halves)
  );

  sync_counters #(.POS_W(POS_W), .IDX_W(IDX_W)) cnt_i (
    .clk(clk), .rst_n(rst_n),
    .half_len_i(half_len), .frame_lines_i(frame_lines),
    .pos_o(pos), .line_start_o(line_start),
    .field_even_o(field_even), .fidx_o(fidx)
  );

  sync_wave #(.POS_W(POS_W), .IDX_W(IDX_W)) wave_i (
    .clk(clk), .rst_n(rst_n),
    .pos_i(pos), .line_start_i(line_start), .field_even_i(field_even),
    .fidx_i(fidx), .half_len_i(half_len), .hsync_w_i(hsync_w),
    .eq_w_i(eq_w), .hblank_w_i(hblank_w), .vblank_halves_i(vblank_halves),
    .hd_n_o(hd_n), .vd_n_o(vd_n), .csync_n_o(csync_n),
    .cblank_n_o(cblank_n), .field_odd_o(field_odd)
  );

endmodule

// File: tb/sync_gen_top_tb_top.sv
module sync_gen_top_tb_top;

  // Scaled timing used for this bench
  localparam int P_EIA_LINES = 25, P_CCIR_LINES = 31;
  localparam int P_L510 = 60, P_L760E = 92, P_L760C = 88;

  // Vector table: std, width, line, hsync, eq, hblank, lines, vblank lines
  localparam int V_CCIR [4] = '{0, 1, 0, 1};
  localparam int V_WIDE [4] = '{0, 0, 1, 1};
  localparam int V_LINE [4] = '{60, 60, 92, 88};
  localparam int V_HSW  [4] = '{5, 5, 7, 7};
  localparam int V_EQ   [4] = '{2, 2, 3, 3};
  localparam int V_HBLK [4] = '{10, 11, 15, 17};
  localparam int V_LNS  [4] = '{25, 31, 25, 31};
  localparam int V_VBLK [4] = '{10, 12, 10, 12};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic std_ccir = 1'b0, wide_760 = 1'b0;
  logic hd_n, vd_n, csync_n, cblank_n, field_odd;

  always #2.5 clk = ~clk;

  sync_gen_top #(
    .EIA_LINES(P_EIA_LINES), .CCIR_LINES(P_CCIR_LINES),
    .LINE_510(P_L510), .LINE_760_EIA(P_L760E), .LINE_760_CCIR(P_L760C),
    .HSYNC_510(5), .HSYNC_760(7), .EQ_510(2), .EQ_760(3),
    .HBLK_EIA_510(10), .HBLK_CCIR_510(11), .HBLK_EIA_760(15), .HBLK_CCIR_760(17),
    .VBLK_EIA(10), .VBLK_CCIR(12)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .std_ccir(std_ccir), .wide_760(wide_760),
    .hd_n(hd_n), .vd_n(vd_n), .csync_n(csync_n), .cblank_n(cblank_n),
    .field_odd(field_odd)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Monitor state, sampled on the falling edge
  int cur_line, cur_hsw, cur_eq, cur_half;
  bit mon_clr = 1'b0;
  int cyc, p_hd, p_vd, p_cs, p_bl;
  int hd_t, hd_per, hd_low, vd_t, vd_per, vd_low, vd_cnt;
  int cs_t, bl_t, eq_cnt, vs_cnt, hs_cnt, bl_short, bl_max, bl_min;
  int align_err, tog_err, prev_fld;

  always @(negedge clk) begin
    if (mon_clr) begin
      cyc = 0; p_hd = 1; p_vd = 1; p_cs = 1; p_bl = 1;
      hd_t = -1; hd_per = 0; hd_low = 0; vd_t = -1; vd_per = 0; vd_low = 0; vd_cnt = 0;
      cs_t = 0; bl_t = 0; eq_cnt = 0; vs_cnt = 0; hs_cnt = 0;
      bl_short = 0; bl_max = 0; bl_min = 1 << 30;
      align_err = 0; tog_err = 0; prev_fld = -1;
    end else begin
      cyc++;
      if (p_hd == 1 && hd_n == 1'b0) begin
        if (hd_t >= 0) hd_per = cyc - hd_t;
        hd_t = cyc;
      end
      if (p_hd == 0 && hd_n == 1'b1) hd_low = cyc - hd_t;
      if (p_vd == 1 && vd_n == 1'b0) begin
        if (vd_t >= 0) vd_per = cyc - vd_t;
        vd_t = cyc;
        vd_cnt++;
        if (field_odd && hd_n) align_err++;
        if (!field_odd && !hd_n) align_err++;
        if (prev_fld == int'(field_odd)) tog_err++;
        prev_fld = int'(field_odd);
      end
      if (p_vd == 0 && vd_n == 1'b1) vd_low = cyc - vd_t;
      if (p_cs == 1 && csync_n == 1'b0) cs_t = cyc;
      if (p_cs == 0 && csync_n == 1'b1) begin
        if (cyc - cs_t == cur_eq) eq_cnt++;
        else if (cyc - cs_t == cur_half - cur_hsw) vs_cnt++;
        else if (cyc - cs_t == cur_hsw) hs_cnt++;
      end
      if (p_bl == 1 && cblank_n == 1'b0) bl_t = cyc;
      if (p_bl == 0 && cblank_n == 1'b1) begin
        if (cyc - bl_t > cur_line) begin
          if (cyc - bl_t > bl_max) bl_max = cyc - bl_t;
          if (cyc - bl_t < bl_min) bl_min = cyc - bl_t;
        end else bl_short = cyc - bl_t;
      end
      p_hd = int'(hd_n); p_vd = int'(vd_n); p_cs = int'(csync_n); p_bl = int'(cblank_n);
    end
  end

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_reset_outputs();
    chk("R9 reset hd_n", int'(hd_n), 1);
    chk("R9 reset vd_n", int'(vd_n), 1);
    chk("R9 reset csync_n", int'(csync_n), 1);
    chk("R9 reset cblank_n", int'(cblank_n), 1);
    chk("R9 reset field_odd", int'(field_odd), 0);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int frame, half, eqn, vsn, hsn;
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      rst_n = 1'b0;
      std_ccir = V_CCIR[m][0];
      wide_760 = V_WIDE[m][0];
      half = V_LINE[m] / 2;
      frame = V_LINE[m] * V_LNS[m];
      cur_line = V_LINE[m]; cur_hsw = V_HSW[m]; cur_eq = V_EQ[m]; cur_half = half;
      #1;
      check_reset_outputs();
      mon_clr = 1'b1;
      wait_clks(3);
      mon_clr = 1'b0;
      rst_n = 1'b1;
      wait_clks(frame);
      #1;
      eqn = eq_cnt; vsn = vs_cnt; hsn = hs_cnt;
      wait_clks(frame + 4);
      #1;
      $display("mode std=%0d wide=%0d", V_CCIR[m], V_WIDE[m]);
      chk("R1 line period", hd_per, V_LINE[m]);
      chk("R2 hsync width", hd_low, V_HSW[m]);
      chk("R3 field period", vd_per, V_LNS[m] * half);
      chk("R4 vd width", vd_low, 6 * half);
      chk("R4 field toggle errors", tog_err, 0);
      chk("R5 equalizing pulses per frame", eqn, 12);
      chk("R6 serrated vsync pulses per frame", vsn, 12);
      chk("R10 normal hsync pulses per frame", hsn, V_LNS[m] - 12);
      chk("R7 line blank width", bl_short, V_HBLK[m]);
      chk("R7 odd field vblank", bl_max, 2 * V_VBLK[m] * half + V_HBLK[m]);
      chk("R7 even field vblank", bl_min, 2 * V_VBLK[m] * half);
      chk("R8 field start alignment errors", align_err, 0);
      chk("R8 field starts seen", int'(vd_cnt >= 4), 1);
    end

    // Directed: reset in mid-frame acts at once, release restarts odd field
    wait_clks(37);
    rst_n = 1'b0;
    #1;
    check_reset_outputs();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R9 restart hd_n", int'(hd_n), 0);
    chk("R9 restart vd_n", int'(vd_n), 0);
    chk("R9 restart csync_n", int'(csync_n), 0);
    chk("R9 restart cblank_n", int'(cblank_n), 0);
    chk("R9 restart field_odd", int'(field_odd), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule